// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Datapath with Squaring Mode

This block is the arithmetic core of a fixed-point signal processing pipeline. It holds a 16-bit multiplier operand `x` and a 32-bit operand `y`. The multiplier uses the upper 16 bits of `y`. It also holds a 32-bit signed product register `p` and two 36-bit accumulators, with four guard bits each. In a single clock cycle it can do three things in parallel. It can form the signed product of `x` and `y`-high into `p`. It can run one ALU operation that combines a source accumulator with `p` or `y` and writes the result to a destination accumulator. It can take one 16-bit operand load from memory data. Instruction decode, address generation and memory stalls are handled elsewhere. The block sees only pre-decoded controls and data strobes.

A three-bit control register sets two things. One bit enables squaring: in that mode, every load of `y`-high also writes `x`. The other two bits choose, for each accumulator, whether an upper-half load keeps the lower half or clears it. With squaring enabled, a table can be squared at one value per cycle. Each cycle loads a new value, multiplies the value loaded in the previous cycle, and moves the product formed in the cycle before that into an accumulator.

Top module: `mac_square_unit`

## Requirements
- R1: While `rst_n` is low, all state is zero at the next clock edge: `x`, `y`, `p`, both accumulators, the flag register and the control register.
- R2: When control bit 0 (square enable) is 1, a load with `ld_sel`=1 (y high) writes `ld_data` into both `y[31:16]` and `x`. When the bit is 0, `x` is not changed by that load.
- R3: With `mul_en` high, `p` takes the signed product of `x` and `y[31:16]` as they were before the edge. Any ALU operation in the same cycle reads the `p` held before the edge.
- R4: The `op_code` encodings are as follows. 0: d=p. 1: d=s+p. 2: d=s-p. 3: d=y. 4: d=s+y. 5: d=s-y. 6: d=s&y. 7: d=s|y. 8: d=s^y. `p` and `y` are sign-extended to 36 bits. The source and the destination are chosen by `op_src` and `op_dst` (0 = a0, 1 = a1).
- R5: Code 9 (s-y) and code 10 (s&y) update the flags only and leave both accumulators unchanged. Codes 11 to 15 change neither the accumulators nor the flags.
- R6: A load with `ld_sel`=3 (a0 high) or 5 (a1 high) writes the sign-extended data to bits [35:16] of that accumulator. It clears bits [15:0] when control bit 1 (for a0) or bit 2 (for a1) is 0, and keeps them when that bit is 1.
- R7: Loads with `ld_sel`=2 (y low), 4 (a0 low) or 6 (a1 low) change only bits [15:0]. A load with `ld_sel`=1 leaves `y[15:0]` unchanged. `ld_sel`=0 loads `x`, and `ld_sel`=7 is ignored.
- R8: For each valid op code from 0 to 10, `flags_q` = {N, Z, V} of the 36-bit result. V is the signed overflow of an add or subtract and is 0 for moves and logic operations. When `op_valid` is low, the flags hold their value.
- R9: When an ALU write and a load target the same accumulator in the same cycle, the ALU result wins. A load to the other accumulator still takes effect.
- R10: A `ctl_wr` pulse loads `ctl_wdata` into the control register. Loads in that same cycle still use the old control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control value: bit0 square enable, bit1 keep a0 low, bit2 keep a1 low |
| ld_valid | input | 1 | Operand load strobe |
| ld_sel | input | 3 | Load target (encoding in R2, R6, R7) |
| ld_data | input | 16 | Load data |
| mul_en | input | 1 | Form product into p |
| op_valid | input | 1 | ALU operation strobe |
| op_code | input | 4 | ALU operation (encoding in R4, R5) |
| op_dst | input | 1 | Destination accumulator |
| op_src | input | 1 | Source accumulator |
| ctl_q | output | 3 | Control register |
| x_q | output | 16 | Operand x |
| y_q | output | 32 | Operand y |
| p_q | output | 32 | Product register |
| a0_q | output | 36 | Accumulator 0 |
| a1_q | output | 36 | Accumulator 1 |
| flags_q | output | 3 | {N, Z, V} |

## Verification
Every result is registered once. A load, a product, an ALU write, a flag update and a control write all show up at the outputs one edge after the cycle that carries the stimulus. Inputs are driven on the falling edge, and a reference model computes the next state at that point. The outputs are compared at the following falling edge, after exactly one rising edge. The squaring case takes three cycles to reach an accumulator (load, then multiply, then transfer). The bench checks it in every intermediate cycle instead of jumping to the end.

// File: rtl/msq_pkg.sv
// Shared encodings for the multiply/ALU datapath.
// Assumes: op and load-select codes are pre-decoded by the instruction unit.
package msq_pkg;
    typedef enum logic [3:0] {
        OP_P_MOV  = 4'd0,
        OP_P_ADD  = 4'd1,
        OP_P_SUB  = 4'd2,
        OP_Y_MOV  = 4'd3,
        OP_Y_ADD  = 4'd4,
        OP_Y_SUB  = 4'd5,
        OP_Y_AND  = 4'd6,
        OP_Y_OR   = 4'd7,
        OP_Y_XOR  = 4'd8,
        OP_TST_SUB = 4'd9,
        OP_TST_AND = 4'd10
    } alu_op_e;

    typedef enum logic [2:0] {
        LD_X    = 3'd0,
        LD_Y_HI = 3'd1,
        LD_Y_LO = 3'd2,
        LD_A0_HI = 3'd3,
        LD_A0_LO = 3'd4,
        LD_A1_HI = 3'd5,
        LD_A1_LO = 3'd6,
        LD_NONE = 3'd7
    } ld_sel_e;

    localparam int CTL_SQ  = 0;
    localparam int CTL_KEEP0 = 1;
endpackage

// File: rtl/msq_ctl_reg.sv
// Control register: square enable and per-accumulator keep-low bits.
// Assumes: a write takes effect from the next cycle on.
module msq_ctl_reg #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] q
);
    // Hold control bits, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= wdata;
    end
endmodule

// File: rtl/msq_operand_regs.sv
// Operand and product registers: x, y (high/low halves) and p = x * y_hi.
// Assumes: at most one load per cycle; the multiply uses pre-edge operands.
module msq_operand_regs
    import msq_pkg::*;
#(
    parameter int DW = 16,
    localparam int YW = 2 * DW,
    localparam int PW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic [2:0]    ld_sel,
    input  logic [DW-1:0] ld_data,
    input  logic          sq_en,
    input  logic          mul_en,
    output logic [DW-1:0] x_q,
    output logic [YW-1:0] y_q,
    output logic [PW-1:0] p_q
);
    logic x_we, yh_we, yl_we;
    logic signed [PW-1:0] prod;

    // Decode which operand register each load writes.
    always_comb begin
        yh_we = ld_valid && (ld_sel == LD_Y_HI);
        yl_we = ld_valid && (ld_sel == LD_Y_LO);
        x_we  = ld_valid && ((ld_sel == LD_X) || (sq_en && ld_sel == LD_Y_HI));
        prod  = $signed(x_q) * $signed(y_q[YW-1:DW]);
    end

    // x register, also written by y-high loads in squaring mode.
    always_ff @(posedge clk) begin
        if (!rst_n)    x_q <= '0;
        else if (x_we) x_q <= ld_data;
    end

    // y register halves, each written independently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q <= '0;
        end else begin
            if (yh_we) y_q[YW-1:DW] <= ld_data;
            if (yl_we) y_q[DW-1:0]  <= ld_data;
        end
    end

    // Product register, one multiply per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      p_q <= '0;
        else if (mul_en) p_q <= prod;
    end
endmodule

// File: rtl/msq_alu.sv
// Combinational ALU: combines a source accumulator with p or y.
// Assumes: p and y are sign-extended to accumulator width before use.
module msq_alu
    import msq_pkg::*;
#(
    parameter int DW = 16,
    parameter int GW = 4,
    localparam int PW = 2 * DW,
    localparam int AW = PW + GW
) (
    input  logic [3:0]    op_code,
    input  logic [AW-1:0] src,
    input  logic [PW-1:0] p_in,
    input  logic [PW-1:0] y_in,
    output logic [AW-1:0] res,
    output logic          wr_en,
    output logic          flag_en,
    output logic [2:0]    flags
);
    logic [AW-1:0] ext_p, ext_y, opnd;
    logic [AW:0]   sum, dif;
    logic          v;

    // Pick the operand and compute both wide add and subtract.
    always_comb begin
        ext_p = {{GW{p_in[PW-1]}}, p_in};
        ext_y = {{GW{y_in[PW-1]}}, y_in};
        opnd  = (op_code <= OP_P_SUB) ? ext_p : ext_y;
        sum   = {src[AW-1], src} + {opnd[AW-1], opnd};
        dif   = {src[AW-1], src} - {opnd[AW-1], opnd};
    end

    // Select the result, write enable and overflow per operation.
    always_comb begin
        res = '0; v = 1'b0; wr_en = 1'b0; flag_en = 1'b1;
        case (op_code)
            OP_P_MOV, OP_Y_MOV: begin res = opnd; wr_en = 1'b1; end
            OP_P_ADD, OP_Y_ADD: begin res = sum[AW-1:0]; v = sum[AW] ^ sum[AW-1]; wr_en = 1'b1; end
            OP_P_SUB, OP_Y_SUB: begin res = dif[AW-1:0]; v = dif[AW] ^ dif[AW-1]; wr_en = 1'b1; end
            OP_Y_AND:   begin res = src & opnd; wr_en = 1'b1; end
            OP_Y_OR:    begin res = src | opnd; wr_en = 1'b1; end
            OP_Y_XOR:   begin res = src ^ opnd; wr_en = 1'b1; end
            OP_TST_SUB: begin res = dif[AW-1:0]; v = dif[AW] ^ dif[AW-1]; end
            OP_TST_AND: res = src & opnd;
            default:    flag_en = 1'b0;
        endcase
        flags = {res[AW-1], (res == '0), v};
    end
endmodule

// File: rtl/msq_acc_bank.sv
// Accumulator bank: per-accumulator half loads and ALU writes.
// Assumes: the ALU write has priority over a load to the same accumulator.
module msq_acc_bank
    import msq_pkg::*;
#(
    parameter int DW = 16,
    parameter int GW = 4,
    parameter int NACC = 2,
    localparam int AW = 2 * DW + GW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [2:0]       ld_sel,
    input  logic [DW-1:0]    ld_data,
    input  logic [NACC-1:0]  keep_lo,
    input  logic             alu_we,
    input  logic             alu_dst,
    input  logic [AW-1:0]    alu_res,
    output logic [NACC*AW-1:0] acc_flat
);
    localparam int HW = AW - DW;

    for (genvar g = 0; g < NACC; g++) begin : g_acc
        localparam logic [2:0] SEL_HI = 3'(int'(LD_A0_HI) + 2 * g);
        localparam logic [2:0] SEL_LO = 3'(int'(LD_A0_LO) + 2 * g);
        logic [AW-1:0] acc;
        logic          hi_we, lo_we, a_we;

        // Decode the write sources for this accumulator.
        always_comb begin
            hi_we = ld_valid && (ld_sel == SEL_HI);
            lo_we = ld_valid && (ld_sel == SEL_LO);
            a_we  = alu_we && (32'(alu_dst) == g);
        end

        // Accumulator update: ALU write first, otherwise half loads.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc <= '0;
            end else if (a_we) begin
                acc <= alu_res;
            end else if (hi_we) begin
                acc[AW-1:DW] <= {{(HW-DW){ld_data[DW-1]}}, ld_data};
                if (!keep_lo[g]) acc[DW-1:0] <= '0;
            end else if (lo_we) begin
                acc[DW-1:0] <= ld_data;
            end
        end

        assign acc_flat[g*AW +: AW] = acc;
    end
endmodule

// File: rtl/mac_square_unit.sv
// Top of the multiply/ALU datapath with squaring mode.
// Assumes: pre-decoded controls, one load and one ALU op per cycle.
module mac_square_unit
    import msq_pkg::*;
#(
    parameter int DW = 16,
    parameter int GW = 4,
    localparam int NACC = 2,
    localparam int CW = 1 + NACC,
    localparam int PW = 2 * DW,
    localparam int AW = PW + GW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [CW-1:0] ctl_wdata,
    input  logic          ld_valid,
    input  logic [2:0]    ld_sel,
    input  logic [DW-1:0] ld_data,
    input  logic          mul_en,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic          op_dst,
    input  logic          op_src,
    output logic [CW-1:0] ctl_q,
    output logic [DW-1:0] x_q,
    output logic [PW-1:0] y_q,
    output logic [PW-1:0] p_q,
    output logic [AW-1:0] a0_q,
    output logic [AW-1:0] a1_q,
    output logic [2:0]    flags_q
);
    logic [NACC*AW-1:0] acc_flat;
    logic [AW-1:0]      src_acc, alu_res;
    logic               alu_wr, flag_en;
    logic [2:0]         alu_flags;

    msq_ctl_reg #(.CW(CW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata), .q(ctl_q)
    );

    msq_operand_regs #(.DW(DW)) u_opnd (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel),
        .ld_data(ld_data), .sq_en(ctl_q[CTL_SQ]), .mul_en(mul_en),
        .x_q(x_q), .y_q(y_q), .p_q(p_q)
    );

    // Route the selected source accumulator to the ALU.
    assign src_acc = op_src ? acc_flat[AW +: AW] : acc_flat[0 +: AW];

    msq_alu #(.DW(DW), .GW(GW)) u_alu (
        .op_code(op_code), .src(src_acc), .p_in(p_q), .y_in(y_q),
        .res(alu_res), .wr_en(alu_wr), .flag_en(flag_en), .flags(alu_flags)
    );

    msq_acc_bank #(.DW(DW), .GW(GW), .NACC(NACC)) u_acc (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel),
        .ld_data(ld_data), .keep_lo(ctl_q[CTL_KEEP0 +: NACC]),
        .alu_we(op_valid && alu_wr), .alu_dst(op_dst), .alu_res(alu_res),
        .acc_flat(acc_flat)
    );

    // Flag register, updated by every recognised valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                    flags_q <= '0;
        else if (op_valid && flag_en)  flags_q <= alu_flags;
    end

    assign a0_q = acc_flat[0 +: AW];
    assign a1_q = acc_flat[AW +: AW];
endmodule

// File: rtl/msq_checker.sv
// Checker for mac_square_unit, attached by bind; observes ports only.
module msq_checker #(
    parameter int DW = 16,
    parameter int GW = 4,
    localparam int PW = 2 * DW,
    localparam int AW = PW + GW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld_valid,
    input logic [2:0]    ld_sel,
    input logic          mul_en,
    input logic          op_valid,
    input logic [3:0]    op_code,
    input logic [2:0]    ctl_q,
    input logic [DW-1:0] x_q,
    input logic [PW-1:0] y_q,
    input logic [PW-1:0] p_q,
    input logic [AW-1:0] a0_q,
    input logic [AW-1:0] a1_q,
    input logic [2:0]    flags_q
);
    logic signed [PW-1:0] prod_c;
    assign prod_c = $signed(x_q) * $signed(y_q[PW-1:DW]);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == '0 && flags_q == '0 && p_q == '0 && a0_q == '0));

    assert_square_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_sel == 3'd1 && ctl_q[0]) |=> (x_q == y_q[PW-1:DW]));

    assert_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mul_en |=> (p_q == $past(prod_c)));

    assert_test_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd9 && !ld_valid) |=> ($stable(a0_q) && $stable(a1_q)));

    assert_keep_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_sel == 3'd3 && ctl_q[1] && !op_valid)
            |=> (a0_q[DW-1:0] == $past(a0_q[DW-1:0])));

    assert_low_load_keeps_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_sel == 3'd2) |=> (y_q[PW-1:DW] == $past(y_q[PW-1:DW])));

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_q));
endmodule

bind mac_square_unit msq_checker #(.DW(DW), .GW(GW)) u_msq_checker (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel),
    .mul_en(mul_en), .op_valid(op_valid), .op_code(op_code), .ctl_q(ctl_q),
    .x_q(x_q), .y_q(y_q), .p_q(p_q), .a0_q(a0_q), .a1_q(a1_q), .flags_q(flags_q)
);

// File: tb/test_mac_square_unit.sv
// Self-checking bench: reference model advanced once per cycle.
module test_mac_square_unit;
    localparam int DW = 16;
    localparam int AW = 36;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_wr = 0; logic [2:0] ctl_wdata = 0;
    logic ld_valid = 0; logic [2:0] ld_sel = 7; logic [15:0] ld_data = 0;
    logic mul_en = 0, op_valid = 0, op_dst = 0, op_src = 0;
    logic [3:0] op_code = 0;
    logic [2:0] ctl_q, flags_q;
    logic [15:0] x_q;
    logic [31:0] y_q, p_q;
    logic [35:0] a0_q, a1_q;

    int n_chk = 0, n_bad = 0;

    // Model state.
    logic [2:0] m_ctl, m_fl;
    logic [15:0] m_x;
    logic [31:0] m_y, m_p;
    logic [35:0] m_a [2];

    mac_square_unit i_mac_square_unit (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_data(ld_data), .mul_en(mul_en),
        .op_valid(op_valid), .op_code(op_code), .op_dst(op_dst), .op_src(op_src),
        .ctl_q(ctl_q), .x_q(x_q), .y_q(y_q), .p_q(p_q), .a0_q(a0_q), .a1_q(a1_q),
        .flags_q(flags_q)
    );

    always #10 clk = ~clk;

    initial begin
        #(20 * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    function automatic logic [35:0] sx32(input logic [31:0] v);
        return {{4{v[31]}}, v};
    endfunction

    // Reference ALU per R4/R5/R8: returns {write, flag_en, flags, result}.
    function automatic logic [40:0] ref_alu(input logic [3:0] op, input logic [35:0] s,
                                            input logic [31:0] p, input logic [31:0] y);
        logic signed [37:0] ws, wo, wr;
        logic [35:0] r; logic v, w, fe;
        logic [35:0] o;
        o = (op <= 4'd2) ? sx32(p) : sx32(y);
        ws = 38'(signed'(s)); wo = 38'(signed'(o));
        r = '0; v = 0; w = 0; fe = 1;
        case (op)
            0, 3: begin r = o; w = 1; end
            1, 4: begin wr = ws + wo; r = wr[35:0]; v = (wr > 38'sh7_FFFF_FFFF) || (wr < -38'sh8_0000_0000); w = 1; end
            2, 5: begin wr = ws - wo; r = wr[35:0]; v = (wr > 38'sh7_FFFF_FFFF) || (wr < -38'sh8_0000_0000); w = 1; end
            6: begin r = s & o; w = 1; end
            7: begin r = s | o; w = 1; end
            8: begin r = s ^ o; w = 1; end
            9: begin wr = ws - wo; r = wr[35:0]; v = (wr > 38'sh7_FFFF_FFFF) || (wr < -38'sh8_0000_0000); end
            10: r = s & o;
            default: fe = 0;
        endcase
        return {w, fe, r[35], (r == 36'd0), v, r};
    endfunction

    // Advance the model by one edge using the currently driven inputs.
    task automatic model_step();
        logic [2:0] nc, nf; logic [15:0] nx; logic [31:0] ny, np; logic [35:0] na [2];
        logic [40:0] a; logic [31:0] prod;
        nc = m_ctl; nf = m_fl; nx = m_x; ny = m_y; np = m_p; na = m_a;
        if (!rst_n) begin
            m_ctl = 0; m_fl = 0; m_x = 0; m_y = 0; m_p = 0; m_a[0] = 0; m_a[1] = 0;
            return;
        end
        if (ctl_wr) nc = ctl_wdata;
        prod = 32'($signed(m_x) * $signed(m_y[31:16]));
        if (mul_en) np = prod;
        if (ld_valid) begin
            case (ld_sel)
                0: nx = ld_data;
                1: begin ny[31:16] = ld_data; if (m_ctl[0]) nx = ld_data; end
                2: ny[15:0] = ld_data;
                3, 5: begin
                    na[(ld_sel == 5) ? 1 : 0][35:16] = {{4{ld_data[15]}}, ld_data};
                    if (!m_ctl[(ld_sel == 5) ? 2 : 1]) na[(ld_sel == 5) ? 1 : 0][15:0] = 0;
                end
                4: na[0][15:0] = ld_data;
                6: na[1][15:0] = ld_data;
                default: ;
            endcase
        end
        a = ref_alu(op_code, m_a[op_src], m_p, m_y);
        if (op_valid && a[39]) nf = a[38:36];
        if (op_valid && a[40]) na[op_dst] = a[35:0];
        m_ctl = nc; m_fl = nf; m_x = nx; m_y = ny; m_p = np; m_a = na;
    endtask

    // Apply driven inputs for one cycle and compare at the next falling edge.
    task automatic cyc(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (ctl_q !== m_ctl || x_q !== m_x || y_q !== m_y || p_q !== m_p ||
            a0_q !== m_a[0] || a1_q !== m_a[1] || flags_q !== m_fl) begin
            n_bad++;
            $display("FAIL %s: got ctl=%h x=%h y=%h p=%h a0=%h a1=%h fl=%b, expected ctl=%h x=%h y=%h p=%h a0=%h a1=%h fl=%b",
                     tag, ctl_q, x_q, y_q, p_q, a0_q, a1_q, flags_q,
                     m_ctl, m_x, m_y, m_p, m_a[0], m_a[1], m_fl);
        end
        ctl_wr = 0; ld_valid = 0; mul_en = 0; op_valid = 0;
    endtask

    task automatic ld(input logic [2:0] s, input logic [15:0] d);
        ld_valid = 1; ld_sel = s; ld_data = d;
    endtask

    task automatic op(input logic [3:0] c, input logic d, input logic s);
        op_valid = 1; op_code = c; op_dst = d; op_src = s;
    endtask

    initial begin
        logic [15:0] tbl [5];
        void'($urandom(32'd1628));
        m_ctl = 'x; m_fl = 'x; m_x = 'x; m_y = 'x; m_p = 'x; m_a[0] = 'x; m_a[1] = 'x;
        @(negedge clk);
        cyc("R1"); cyc("R1");
        rst_n = 1;

        // R2: square bit clear, y-high load leaves x alone.
        ld(0, 16'h0011); cyc("R7");
        ld(1, 16'h1234); cyc("R2");
        // R10: enable squaring; load in the same cycle still uses old bit.
        ctl_wr = 1; ctl_wdata = 3'b001; ld(1, 16'h4321); cyc("R10");
        ld(1, 16'hFFFE); cyc("R2");

        // R3: square a table at one value per cycle.
        tbl = '{16'h0003, 16'hFFF9, 16'h7FFF, 16'h8000, 16'h0101};
        for (int i = 0; i < 7; i++) begin
            if (i < 5) ld(1, tbl[i]);
            if (i >= 1 && i < 6) mul_en = 1;
            if (i >= 2) op((i % 2) ? 4'd1 : 4'd0, 1'(i % 2), 1'(i % 2));
            cyc("R3");
        end

        // R6: keep-low versus clear on accumulator high loads.
        ld(4, 16'hBEEF); cyc("R7");
        ld(3, 16'h8001); cyc("R6");
        ld(6, 16'hCAFE); cyc("R7");
        ctl_wr = 1; ctl_wdata = 3'b110; cyc("R10");
        ld(5, 16'h7FFF); cyc("R6");
        ld(4, 16'h1357); cyc("R6");
        ld(3, 16'h0042); cyc("R6");
        ld(2, 16'h5A5A); cyc("R7");
        ld(7, 16'hFFFF); cyc("R7");

        // R4: every writing op with both source/destination pairs.
        for (int c = 0; c < 9; c++) begin
            op(4'(c), 1'(c % 2), 1'((c / 2) % 2)); cyc("R4");
        end
        // R5: compare and unsupported codes.
        op(4'd9, 0, 0); cyc("R5");
        op(4'd10, 1, 1); cyc("R5");
        op(4'd12, 0, 1); cyc("R5");
        op(4'd15, 1, 0); cyc("R5");
        // R8: drive a0 into positive overflow by repeated adds of a large y.
        ld(1, 16'h7FFF); cyc("R8");
        ld(2, 16'hFFFF); cyc("R8");
        for (int i = 0; i < 20; i++) begin op(4'd4, 0, 0); cyc("R8"); end
        op(4'd5, 1, 0); cyc("R8");
        cyc("R8");
        // R9: ALU and load hit the same accumulator, then different ones.
        op(4'd3, 0, 0); ld(3, 16'h1111); cyc("R9");
        op(4'd3, 0, 1); ld(6, 16'h2222); cyc("R9");

        // Random mix of everything.
        for (int i = 0; i < 600; i++) begin
            ctl_wr = ($urandom % 16) == 0; ctl_wdata = 3'($urandom);
            ld_valid = 1'($urandom); ld_sel = 3'($urandom); ld_data = 16'($urandom);
            mul_en = 1'($urandom);
            op_valid = 1'($urandom); op_code = 4'($urandom);
            op_dst = 1'($urandom); op_src = 1'($urandom);
            cyc("R4");
        end

        rst_n = 0; cyc("R1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule